// File: doc/BRIEF.md
# Thirty-Two Line GPIO Bank with Grouped Interrupts

This block is a bank of general-purpose I/O lines, controlled through a simple word-addressed register bus. Each line can be an input or an output. An output line drives the value held in an output latch, or a shared square wave when its blink bit is set. Every input passes through a two-flop synchronizer. A per-line polarity bit then optionally inverts it, and the result is the data-in value that software reads and that the interrupt logic watches.

Each line can raise an interrupt in two ways. In level mode the request is live while the adjusted data-in bit is high and the level mask allows it. In edge mode a rising transition of the adjusted bit sets a sticky cause bit, which software clears by writing zero to it. The pending requests are OR-reduced in groups of eight lines into four summary interrupt outputs.

The blink generator is a two-state machine with the states PH_LOW and PH_HIGH. A free-running counter counts one half-period. Its terminal count is the only transition: PH_LOW goes to PH_HIGH, and PH_HIGH goes back to PH_LOW. All blinking lines follow this one phase, so they toggle together.

Top module: `gpio_bank32`

## Requirements
- R1: After reset the output latch, blink enable, polarity, edge cause, edge mask and level mask all read zero. The direction register reads all ones. pad_oe, pad_out and irq_grp are all zero.
- R2: Registers are selected by the full byte address. 0x00 is the output latch, 0x04 direction, 0x08 blink enable, 0x0C polarity, 0x10 data-in and 0x14 edge cause. Any other address reads zero and ignores writes. Data-in is read-only: a write to it changes nothing. Every other listed register reads back what was written, except the edge cause.
- R3: A direction bit of 1 makes the line an input: pad_oe low and pad_out low. A bit of 0 makes it an output: pad_oe high and pad_out equal to the output-latch bit when blink is off.
- R4: Data-in bit i equals pad_in[i] XOR polarity bit i. pad_in passes two flops, so a pad change sampled at one rising edge is readable after the second rising edge.
- R5: Line i asks for a level interrupt while data-in bit i and level-mask bit i are both 1. Nothing is latched: the request drops as soon as either bit is 0.
- R6: A 0 to 1 change of data-in bit i sets edge-cause bit i. Writing 0 to that bit clears it. Writing 1 leaves it unchanged. Only a cause write can clear it.
- R7: If a new rising edge and a write of 0 to the same cause bit fall in the same cycle, the bit is set after that cycle.
- R8: Line i is pending when (data-in AND level-mask) OR (edge-cause AND edge-mask) holds for bit i. irq_grp[g] is the OR of pending lines 8g to 8g+7. With both masks zero, all irq_grp bits stay low.
- R9: An output line with its blink bit set drives the shared blink phase instead of its latch bit. The phase changes every BLINK_HALF clock cycles, and all blinking lines are equal at all times.
- R10: The edge mask sits at 0x18 + MASK_OFS and the level mask at 0x1C + MASK_OFS. With a non-zero offset, the unshifted addresses read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | AW | Byte address of the register |
| bus_wdata | input | NLINES | Write data |
| bus_rdata | output | NLINES | Read data of the addressed register (combinational) |
| pad_in | input | NLINES | Raw line inputs |
| pad_out | output | NLINES | Line output values |
| pad_oe | output | NLINES | Per-line output enable |
| irq_grp | output | NLINES/GROUP_W | Summary interrupt per group of eight lines |

## Verification
The bench targets the cycle where a fresh edge and a clearing write meet. A design that let the write win would lose an interrupt, and the cause bit would read zero. It measures the two-stage input latency exactly; one register too many or too few shows as early or late data-in. It drops a level request after its input falls, which catches any latching of level causes. It writes the unshifted mask addresses with a non-zero offset, and a decoder that ignored the offset would accept those writes. Timed blink intervals and random register and pad traffic, checked against a bench model, cover polarity-made edges and group wiring.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    typedef enum logic [3:0] {
        SEL_OUT,
        SEL_DIR,
        SEL_BLINK,
        SEL_POL,
        SEL_DIN,
        SEL_CAUSE,
        SEL_EMASK,
        SEL_LMASK,
        SEL_NONE
    } reg_sel_e;

    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } blink_ph_e;

    localparam int OFS_OUT   = 'h00;
    localparam int OFS_DIR   = 'h04;
    localparam int OFS_BLINK = 'h08;
    localparam int OFS_POL   = 'h0C;
    localparam int OFS_DIN   = 'h10;
    localparam int OFS_CAUSE = 'h14;
    localparam int OFS_EMASK = 'h18;
    localparam int OFS_LMASK = 'h1C;

endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_bank_pkg::*;
#(
    parameter int N        = 32,
    parameter int AW       = 8,
    parameter int MASK_OFS = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [N-1:0]  wdata,
    output reg_sel_e      sel,
    output logic          cause_wr,
    output logic [N-1:0]  out_q,
    output logic [N-1:0]  dir_q,
    output logic [N-1:0]  blink_q,
    output logic [N-1:0]  pol_q,
    output logic [N-1:0]  emask_q,
    output logic [N-1:0]  lmask_q
);

    localparam logic [AW-1:0] A_OUT   = AW'(OFS_OUT);
    localparam logic [AW-1:0] A_DIR   = AW'(OFS_DIR);
    localparam logic [AW-1:0] A_BLINK = AW'(OFS_BLINK);
    localparam logic [AW-1:0] A_POL   = AW'(OFS_POL);
    localparam logic [AW-1:0] A_DIN   = AW'(OFS_DIN);
    localparam logic [AW-1:0] A_CAUSE = AW'(OFS_CAUSE);
    localparam logic [AW-1:0] A_EMASK = AW'(OFS_EMASK + MASK_OFS);
    localparam logic [AW-1:0] A_LMASK = AW'(OFS_LMASK + MASK_OFS);

    // Fixed registers decode first, so a small offset cannot shadow them.
    always_comb begin
        if      (addr == A_OUT)   sel = SEL_OUT;
        else if (addr == A_DIR)   sel = SEL_DIR;
        else if (addr == A_BLINK) sel = SEL_BLINK;
        else if (addr == A_POL)   sel = SEL_POL;
        else if (addr == A_DIN)   sel = SEL_DIN;
        else if (addr == A_CAUSE) sel = SEL_CAUSE;
        else if (addr == A_EMASK) sel = SEL_EMASK;
        else if (addr == A_LMASK) sel = SEL_LMASK;
        else                      sel = SEL_NONE;
    end

    always_comb cause_wr = wr && (sel == SEL_CAUSE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q   <= '0;
            dir_q   <= '1;
            blink_q <= '0;
            pol_q   <= '0;
            emask_q <= '0;
            lmask_q <= '0;
        end else if (wr) begin
            unique case (sel)
                SEL_OUT:   out_q   <= wdata;
                SEL_DIR:   dir_q   <= wdata;
                SEL_BLINK: blink_q <= wdata;
                SEL_POL:   pol_q   <= wdata;
                SEL_EMASK: emask_q <= wdata;
                SEL_LMASK: lmask_q <= wdata;
                default:   ;
            endcase
        end
    end

endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw,
    output logic [N-1:0] synced
);

    for (genvar i = 0; i < N; i++) begin : g_line
        logic [1:0] stage_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q <= '0;
            else        stage_q <= {stage_q[0], raw[i]};
        end
        always_comb synced[i] = stage_q[1];
    end

endmodule

// File: rtl/gpio_blink.sv
module gpio_blink
    import gpio_bank_pkg::*;
#(
    parameter int HALF = 1024
) (
    input  logic                    clk,
    input  logic                    rst_n,
    output logic                    phase,
    output logic [$clog2(HALF)-1:0] cnt_o
);

    localparam int CW = $clog2(HALF);
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    blink_ph_e      state_q, state_d;
    logic [CW-1:0]  cnt_q, cnt_d;
    logic           wrap;

    always_comb wrap = (cnt_q == LAST);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PH_LOW;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state
    always_comb begin
        cnt_d   = wrap ? '0 : cnt_q + 1'b1;
        state_d = state_q;
        unique case (state_q)
            PH_LOW:  if (wrap) state_d = PH_HIGH;
            PH_HIGH: if (wrap) state_d = PH_LOW;
        endcase
    end

    // outputs
    always_comb begin
        phase = (state_q == PH_HIGH);
        cnt_o = cnt_q;
    end

endmodule

// File: rtl/gpio_irq.sv
module gpio_irq #(
    parameter int N  = 32,
    parameter int GW = 8,
    parameter int NG = N / GW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  din,
    input  logic [N-1:0]  lmask,
    input  logic [N-1:0]  emask,
    input  logic          cause_wr,
    input  logic [N-1:0]  wdata,
    output logic [N-1:0]  cause_q,
    output logic [N-1:0]  din_prev_q,
    output logic [NG-1:0] irq
);

    logic [N-1:0] rise;
    logic [N-1:0] cause_d;
    logic [N-1:0] pend;

    always_comb begin
        rise    = din & ~din_prev_q;
        cause_d = cause_wr ? (cause_q & wdata) : cause_q;
        cause_d = cause_d | rise;   // a new edge beats a clearing write
        pend    = (din & lmask) | (cause_q & emask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            din_prev_q <= '0;
            cause_q    <= '0;
        end else begin
            din_prev_q <= din;
            cause_q    <= cause_d;
        end
    end

    for (genvar g = 0; g < NG; g++) begin : g_grp
        always_comb irq[g] = |pend[g*GW +: GW];
    end

endmodule

// File: rtl/gpio_bank32.sv
module gpio_bank32
    import gpio_bank_pkg::*;
#(
    parameter int NLINES     = 32,
    parameter int GROUP_W    = 8,
    parameter int AW         = 8,
    parameter int BLINK_HALF = 1024,
    parameter int MASK_OFS   = 0
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_wr,
    input  logic [AW-1:0]               bus_addr,
    input  logic [NLINES-1:0]           bus_wdata,
    output logic [NLINES-1:0]           bus_rdata,
    input  logic [NLINES-1:0]           pad_in,
    output logic [NLINES-1:0]           pad_out,
    output logic [NLINES-1:0]           pad_oe,
    output logic [NLINES/GROUP_W-1:0]   irq_grp
);

    localparam int NG = NLINES / GROUP_W;
    localparam int CW = $clog2(BLINK_HALF);

    reg_sel_e              sel;
    logic                  cause_wr;
    logic [NLINES-1:0]     out_q, dir_q, blink_q, pol_q, emask_q, lmask_q;
    logic [NLINES-1:0]     pin_sync, din, edge_cause, din_prev;
    logic                  blink_phase;
    logic [CW-1:0]         blink_cnt;

    gpio_regs #(.N(NLINES), .AW(AW), .MASK_OFS(MASK_OFS)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
        .sel(sel), .cause_wr(cause_wr),
        .out_q(out_q), .dir_q(dir_q), .blink_q(blink_q), .pol_q(pol_q),
        .emask_q(emask_q), .lmask_q(lmask_q)
    );

    gpio_sync #(.N(NLINES)) u_sync (
        .clk(clk), .rst_n(rst_n), .raw(pad_in), .synced(pin_sync)
    );

    always_comb din = pin_sync ^ pol_q;

    gpio_irq #(.N(NLINES), .GW(GROUP_W), .NG(NG)) u_irq (
        .clk(clk), .rst_n(rst_n), .din(din), .lmask(lmask_q), .emask(emask_q),
        .cause_wr(cause_wr), .wdata(bus_wdata),
        .cause_q(edge_cause), .din_prev_q(din_prev), .irq(irq_grp)
    );

    gpio_blink #(.HALF(BLINK_HALF)) u_blink (
        .clk(clk), .rst_n(rst_n), .phase(blink_phase), .cnt_o(blink_cnt)
    );

    always_comb begin
        pad_oe  = ~dir_q;
        pad_out = ~dir_q & ((blink_q & {NLINES{blink_phase}}) | (~blink_q & out_q));
    end

    always_comb begin
        unique case (sel)
            SEL_OUT:   bus_rdata = out_q;
            SEL_DIR:   bus_rdata = dir_q;
            SEL_BLINK: bus_rdata = blink_q;
            SEL_POL:   bus_rdata = pol_q;
            SEL_DIN:   bus_rdata = din;
            SEL_CAUSE: bus_rdata = edge_cause;
            SEL_EMASK: bus_rdata = emask_q;
            SEL_LMASK: bus_rdata = lmask_q;
            default:   bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/gpio_bank32_chk.sv
module gpio_bank32_chk #(
    parameter int N    = 32,
    parameter int NG   = 4,
    parameter int HALF = 1024
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    cause_wr,
    input logic [N-1:0]            cause,
    input logic [N-1:0]            din,
    input logic [N-1:0]            din_prev,
    input logic [N-1:0]            lmask,
    input logic [N-1:0]            emask,
    input logic [N-1:0]            dir,
    input logic [N-1:0]            pad_out,
    input logic [NG-1:0]           irq,
    input logic                    phase,
    input logic [$clog2(HALF)-1:0] cnt
);

    localparam logic [$clog2(HALF)-1:0] LAST = $clog2(HALF)'(HALF - 1);

    AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !cause_wr |=> ((cause & $past(cause)) == $past(cause))); // R6

    AST_EDGE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ((din & ~din_prev) != '0) |=> ((cause & $past(din & ~din_prev)) == $past(din & ~din_prev))); // R7

    AST_QUIET_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
        (lmask == '0 && emask == '0) |-> (irq == '0)); // R8

    AST_INPUT_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_out & dir) == '0)); // R3

    AST_BLINK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != LAST) |=> $stable(phase)); // R9

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt <= LAST)); // R9

endmodule

bind gpio_bank32 gpio_bank32_chk #(.N(NLINES), .NG(NLINES / GROUP_W), .HALF(BLINK_HALF)) u_chk (
    .clk(clk), .rst_n(rst_n), .cause_wr(cause_wr), .cause(edge_cause), .din(din),
    .din_prev(din_prev), .lmask(lmask_q), .emask(emask_q), .dir(dir_q),
    .pad_out(pad_out), .irq(irq_grp), .phase(blink_phase), .cnt(blink_cnt)
);

// File: tb/sim_gpio_bank32.sv
`timescale 1ns/1ps
module sim_gpio_bank32;

    localparam int N    = 32;
    localparam int BH   = 6;
    localparam int MOFS = 'h20;
    localparam logic [7:0] A_OUT = 8'h00, A_DIR = 8'h04, A_BLK = 8'h08, A_POL = 8'h0C,
                           A_DIN = 8'h10, A_CAU = 8'h14,
                           A_EM = 8'(8'h18 + MOFS), A_LM = 8'(8'h1C + MOFS);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic [N-1:0]  bus_wdata = '0;
    logic [N-1:0]  bus_rdata;
    logic [N-1:0]  pad_in = '0;
    logic [N-1:0]  pad_out, pad_oe;
    logic [3:0]    irq_grp;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    logic [N-1:0] m_out, m_dir, m_blk, m_pol, m_em, m_lm, m_cause, m_old;

    always #2.5 clk = ~clk;

    gpio_bank32 #(.NLINES(N), .GROUP_W(8), .AW(8), .BLINK_HALF(BH), .MASK_OFS(MOFS)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .irq_grp(irq_grp)
    );

    task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [N-1:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [N-1:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    function automatic logic [3:0] exp_irq();
        logic [N-1:0] p;
        logic [3:0] r;
        p = ((m_old & m_lm) | (m_cause & m_em));
        for (int g = 0; g < 4; g++) r[g] = |p[g*8 +: 8];
        return r;
    endfunction

    function automatic logic [N-1:0] exp_pad_fixed();
        return ~m_dir & ~m_blk & m_out;
    endfunction

    // wait for the input path to settle and apply rising edges to the model
    task automatic settle();
        logic [N-1:0] nd;
        step(3);
        nd = pad_in ^ m_pol;
        m_cause = m_cause | (nd & ~m_old);
        m_old = nd;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; bus_wr = 1'b0; pad_in = '0;
        step(3);
        rst_n = 1'b1;
        step(1);
        m_out = '0; m_dir = '1; m_blk = '0; m_pol = '0; m_em = '0; m_lm = '0;
        m_cause = '0; m_old = '0;
    endtask

    initial begin
        #500000;
        n_err++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [N-1:0] v;
        void'($urandom(32'd4242));
        do_reset();

        // R1 reset state
        rd(A_OUT, v); chk("R1 out", v, '0);
        rd(A_DIR, v); chk("R1 dir", v, '1);
        rd(A_BLK, v); chk("R1 blink", v, '0);
        rd(A_POL, v); chk("R1 pol", v, '0);
        rd(A_CAU, v); chk("R1 cause", v, '0);
        rd(A_EM, v);  chk("R1 emask", v, '0);
        rd(A_LM, v);  chk("R1 lmask", v, '0);
        chk("R1 pad_oe", pad_oe, '0);
        chk("R1 pad_out", pad_out, '0);
        chk("R1 irq", 32'(irq_grp), '0);

        // R2 readback, read-only data-in, unmapped address
        wr(A_OUT, 32'hA5A5_0F0F); rd(A_OUT, v); chk("R2 out rb", v, 32'hA5A5_0F0F);
        wr(A_BLK, 32'h0000_1234); rd(A_BLK, v); chk("R2 blink rb", v, 32'h0000_1234);
        wr(A_BLK, '0);
        wr(A_POL, 32'h8000_0001); rd(A_POL, v); chk("R2 pol rb", v, 32'h8000_0001);
        wr(A_DIN, 32'h5555_5555); step(2); rd(A_DIN, v); chk("R2 din read-only", v, 32'h8000_0001);
        wr(A_POL, '0);
        wr(8'h40, 32'hFFFF_FFFF); rd(8'h40, v); chk("R2 unmapped", v, '0);
        rd(8'h05, v); chk("R2 misaligned", v, '0);

        // R10 offset mask placement
        wr(A_EM, 32'h0000_00F0); rd(A_EM, v); chk("R10 emask rb", v, 32'h0000_00F0);
        wr(A_LM, 32'h0F00_0000); rd(A_LM, v); chk("R10 lmask rb", v, 32'h0F00_0000);
        wr(8'h18, 32'hFFFF_FFFF); rd(8'h18, v); chk("R10 old emask addr", v, '0);
        wr(8'h1C, 32'hFFFF_FFFF);
        rd(A_EM, v); chk("R10 emask untouched", v, 32'h0000_00F0);
        rd(A_LM, v); chk("R10 lmask untouched", v, 32'h0F00_0000);
        wr(A_EM, '0); wr(A_LM, '0);

        // R3 direction
        wr(A_DIR, 32'hFFFF_0000); step(1);
        chk("R3 pad_oe", pad_oe, 32'h0000_FFFF);
        chk("R3 pad_out", pad_out, 32'h0000_0F0F);
        wr(A_DIR, '1); step(1);
        chk("R3 all inputs", pad_out, '0);

        // R4 two-stage latency and polarity
        pad_in = 32'h0000_00C3;
        step(1); rd(A_DIN, v); chk("R4 din after one edge", v, '0);
        step(1); rd(A_DIN, v); chk("R4 din after two edges", v, 32'h0000_00C3);
        wr(A_POL, 32'h0000_000F); step(1); rd(A_DIN, v); chk("R4 inverted", v, 32'h0000_00CC);
        wr(A_POL, '0); pad_in = '0; step(4);
        wr(A_CAU, '0); step(1);

        // R5 level, not latched
        wr(A_LM, 32'h0001_0000);
        pad_in = 32'h0001_0000; step(3);
        chk("R5 level high", 32'(irq_grp), 32'h4);
        pad_in = '0; step(3);
        chk("R5 level drops", 32'(irq_grp), '0);
        wr(A_LM, '0);

        // R6 edge cause set, write one keeps, write zero clears
        wr(A_CAU, '0);
        wr(A_EM, 32'h0000_0008);
        pad_in = 32'h0000_0008; step(3);
        rd(A_CAU, v); chk("R6 set on rise", v, 32'h0000_0008);
        pad_in = '0; step(3);
        rd(A_CAU, v); chk("R6 held after fall", v, 32'h0000_0008);
        chk("R8 edge irq grp0", 32'(irq_grp), 32'h1);
        wr(A_CAU, 32'h0000_0008); step(1);
        rd(A_CAU, v); chk("R6 write one keeps", v, 32'h0000_0008);
        wr(A_CAU, 32'hFFFF_FFF7); step(1);
        rd(A_CAU, v); chk("R6 write zero clears", v, '0);
        chk("R6 irq cleared", 32'(irq_grp), '0);

        // R7 edge in the same cycle as the clear
        pad_in = 32'h0000_0008; step(3);
        pad_in = '0; step(3);
        pad_in = 32'h0000_0008;
        step(2);
        wr(A_CAU, '0);
        rd(A_CAU, v); chk("R7 edge wins", v, 32'h0000_0008);
        pad_in = '0; step(3);
        wr(A_CAU, '0); wr(A_EM, '0);

        // R8 grouping
        wr(A_LM, '1);
        for (int g = 0; g < 4; g++) begin
            pad_in = 32'(1) << (g * 8 + 7 - g); step(3);
            chk("R8 group select", 32'(irq_grp), 32'(1) << g);
        end
        pad_in = '0; step(3);
        wr(A_LM, '0); wr(A_CAU, '0);

        // R9 blink
        wr(A_OUT, 32'h0000_0020);
        wr(A_DIR, 32'hFFFF_FFDE);
        wr(A_BLK, 32'h0000_8021);
        begin
            int last_t;
            int t;
            logic prev;
            int seen;
            seen = 0; last_t = 0; t = 0;
            prev = pad_out[0];
            for (int c = 0; c < 6 * BH; c++) begin
                step(1); t++;
                chk("R9 lines in phase", 32'(pad_out[5]), 32'(pad_out[0]));
                chk("R9 blink on input line", 32'(pad_out[15]), '0);
                if (pad_out[0] !== prev) begin
                    if (seen > 0) chk("R9 half period", 32'(t - last_t), 32'(BH));
                    seen++; last_t = t; prev = pad_out[0];
                end
            end
            chk("R9 toggles seen", 32'(seen >= 4), 32'd1);
        end

        // random traffic against the model
        do_reset();
        for (int it = 0; it < 300; it++) begin
            logic [N-1:0] d;
            int op;
            op = $urandom % 9;
            d  = $urandom;
            unique case (op)
                0: begin wr(A_OUT, d); m_out = d; end
                1: begin wr(A_DIR, d); m_dir = d; end
                2: begin wr(A_BLK, d); m_blk = d; end
                3: begin wr(A_POL, d); m_pol = d; end
                4: begin wr(A_EM, d);  m_em = d; end
                5: begin wr(A_LM, d);  m_lm = d; end
                6: begin wr(A_CAU, d); m_cause = m_cause & d; end
                default: pad_in = d;
            endcase
            settle();
            rd(A_DIN, v); chk("R4 random din", v, m_old);
            rd(A_CAU, v); chk("R6 random cause", v, m_cause);
            chk("R8 random irq", 32'(irq_grp), 32'(exp_irq()));
            chk("R3 random oe", pad_oe, ~m_dir);
            chk("R3 random out", pad_out & ~m_blk, exp_pad_fixed());
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule